// File: doc/BRIEF.md
# CAN Bit Timing Parameter Solver

This block searches for CAN bit timing settings. A request gives three values: the clock frequency at the prescaler input in MHz (1 to 300), the wanted bit rate in kbit/s, and the wanted sample point in per-mille (100 to 900, where 875 means 87.5 %). The engine then steps through every prescaler from 1 to 64. For each prescaler it tries every bit length from 25 down to 8 time quanta. It keeps only candidates whose bit time matches the requested rate exactly. From those it picks the one whose sample point lies closest to the target.

A bit is laid out as one synchronisation quantum, then a pre-sample segment (TSEG1, the propagation and first phase segments merged), then a post-sample segment (TSEG2). The result is given two ways: as separate fields, and as a two-byte register image. The first byte holds the prescaler. The second byte holds both segment lengths.

The request is taken with a single-cycle `start` pulse while the block is idle. The search always takes the same number of cycles. The result is reported with a single-cycle `done` pulse, and the outputs hold their values until the next result.

Top module: `can_bt_solver`

## Requirements
- R1: While reset is held and after its release, `busy`, `done`, `found` and every result output are zero.
- R2: When `found` is 1, `presc` × (1 + `tseg1` + `tseg2`) × `rate_kbps` equals `clk_mhz` × 1000.
- R3: When `found` is 1, these ranges hold:
  - `presc` is 1 to 64;
  - `tseg1` is 1 to 16;
  - `tseg2` is 1 to 8;
  - the total quanta 1 + `tseg1` + `tseg2` is 8 to 25.
- R4: For a total of N quanta and target T, TSEG2 is round-half-up of (1000 − T)·N/1000. It is then clamped to the range max(1, N − 17) to min(8, N − 2). TSEG1 is N − 1 − TSEG2.
- R5: Among the exact candidates, the block selects the one with the smallest sample-point error |`sp_ach_pm` − T|. On equal error, the larger total quanta count wins.
- R6: `sp_ach_pm` is floor((1 + `tseg1`) × 1000 / total quanta).
- R7: The register image is packed as follows:
  - `btr_presc` = `presc` − 1;
  - `btr_seg` bits 6:4 = `tseg2` − 1;
  - `btr_seg` bits 3:0 = `tseg1` − 1;
  - `btr_seg` bit 7 = 0.
- R8: If no exact candidate exists, `done` pulses with `found` = 0, and every result field and both image bytes are zero.
- R9: `done` is a one-cycle pulse.
  - It rises exactly 1153 cycles after the clock edge that accepts `start` (64 prescalers × 18 quanta counts + 1).
  - `busy` is 1 from the cycle after acceptance until `done` rises.
- R10: A `start` pulse seen while `busy` is 1 has no effect. The inputs are captured at acceptance, so changing them during the search does not alter the result.
- R11: The request 8 MHz, 125 kbit/s, target 875 yields `btr_presc` = 0x03 and `btr_seg` = 0x1C (prescaler 4, 16 quanta).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, accepted when idle |
| clk_mhz | input | 9 | Prescaler input clock in MHz |
| rate_kbps | input | 10 | Target bit rate in kbit/s |
| sp_target_pm | input | 10 | Target sample point in per-mille |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result pulse |
| found | output | 1 | An exact setting was found |
| presc | output | 7 | Selected prescaler |
| tseg1 | output | 5 | Pre-sample segment in quanta |
| tseg2 | output | 4 | Post-sample segment in quanta |
| sp_ach_pm | output | 10 | Achieved sample point in per-mille |
| btr_presc | output | 8 | Register image byte 0 |
| btr_seg | output | 8 | Register image byte 1 |

## Verification
The edge that accepts `start` raises `busy` one cycle later. `done` and every result field change together 1153 cycles after that edge and then hold until the next accepted request. The bench's reference model counts the same 1153 edges from its own copy of the accepted request. It compares `busy`, `done` and every result at each falling edge, so an output that changes one cycle early or late is reported in that exact cycle. Field values such as the exact bit time, the segment ranges and the worked example are checked at the falling edge on which `done` is seen.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

  typedef enum logic [1:0] {
    SCAN_IDLE = 2'd0,
    SCAN_RUN  = 2'd1,
    SCAN_FIN  = 2'd2
  } scan_state_e;

  localparam int PERMILLE = 1000;

  // Post-sample segment for N quanta: round half up, then keep both segments legal
  function automatic int bt_pick_tseg2(int sp_pm, int nq, int t1max, int t2max);
    int spc, r, lo, hi;
    spc = (sp_pm > PERMILLE) ? PERMILLE : sp_pm;
    r   = ((PERMILLE - spc) * nq + PERMILLE / 2) / PERMILLE;
    lo  = nq - t1max - 1;
    if (lo < 1) lo = 1;
    hi  = nq - 2;
    if (hi > t2max) hi = t2max;
    if (r < lo) r = lo;
    if (r > hi) r = hi;
    return r;
  endfunction

  // Sample point in per-mille, truncated
  function automatic int bt_sample_pm(int nq, int t2);
    if (nq <= 0) return 0;
    return ((nq - t2) * PERMILLE) / nq;
  endfunction

  function automatic int bt_abs_diff(int a, int b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

endpackage

// File: rtl/can_bt_scan.sv
module can_bt_scan
  import can_bt_pkg::*;
#(
  parameter int unsigned PRESC_MAX = 64,
  parameter int unsigned NQ_MIN    = 8,
  parameter int unsigned NQ_MAX    = 25,
  localparam int unsigned PW  = $clog2(PRESC_MAX + 1),
  localparam int unsigned NQW = $clog2(NQ_MAX + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  output logic           busy,
  output logic           start_accept,
  output logic           eval_en,
  output logic           scan_last,
  output logic           finish,
  output logic [PW-1:0]  presc_q,
  output logic [NQW-1:0] nq_q
);

  scan_state_e state_q;

  logic at_nq_floor;
  logic at_presc_top;

  assign at_nq_floor  = (nq_q == NQW'(NQ_MIN));
  assign at_presc_top = (presc_q == PW'(PRESC_MAX));
  assign start_accept = (state_q == SCAN_IDLE) && start;
  assign eval_en      = (state_q == SCAN_RUN);
  assign scan_last    = eval_en && at_nq_floor && at_presc_top;
  assign finish       = (state_q == SCAN_FIN);
  assign busy         = (state_q != SCAN_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SCAN_IDLE;
      presc_q <= '0;
      nq_q    <= '0;
    end else begin
      unique case (state_q)
        SCAN_IDLE: begin
          if (start) begin
            state_q <= SCAN_RUN;
            presc_q <= PW'(1);
            nq_q    <= NQW'(NQ_MAX);
          end
        end
        SCAN_RUN: begin
          if (scan_last) begin
            state_q <= SCAN_FIN;
          end else if (at_nq_floor) begin
            nq_q    <= NQW'(NQ_MAX);
            presc_q <= presc_q + PW'(1);
          end else begin
            nq_q <= nq_q - NQW'(1);
          end
        end
        SCAN_FIN: state_q <= SCAN_IDLE;
        default:  state_q <= SCAN_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/can_bt_eval.sv
module can_bt_eval
  import can_bt_pkg::*;
#(
  parameter int unsigned PW        = 7,
  parameter int unsigned NQW       = 5,
  parameter int unsigned T1W       = 5,
  parameter int unsigned T2W       = 4,
  parameter int unsigned CW        = 9,
  parameter int unsigned RW        = 10,
  parameter int unsigned SW        = 10,
  parameter int unsigned TSEG1_MAX = 16,
  parameter int unsigned TSEG2_MAX = 8
) (
  input  logic [PW-1:0]  presc,
  input  logic [NQW-1:0] nq,
  input  logic [CW-1:0]  clk_mhz,
  input  logic [RW-1:0]  rate_kbps,
  input  logic [SW-1:0]  sp_target,
  output logic           cand_valid,
  output logic [T1W-1:0] cand_t1,
  output logic [T2W-1:0] cand_t2,
  output logic [SW-1:0]  cand_sp,
  output logic [SW-1:0]  cand_err
);

  int need_i, have_i, t1_i, t2_i, sp_i, err_i;

  always_comb begin
    need_i = int'(clk_mhz) * PERMILLE;
    have_i = int'(presc) * int'(nq) * int'(rate_kbps);
    t2_i   = bt_pick_tseg2(int'(sp_target), int'(nq), int'(TSEG1_MAX), int'(TSEG2_MAX));
    t1_i   = int'(nq) - 1 - t2_i;
    sp_i   = bt_sample_pm(int'(nq), t2_i);
    err_i  = bt_abs_diff(sp_i, int'(sp_target));
  end

  assign cand_valid = (rate_kbps != '0) && (nq != '0) && (need_i == have_i);
  assign cand_t1    = T1W'(t1_i);
  assign cand_t2    = T2W'(t2_i);
  assign cand_sp    = SW'(sp_i);
  assign cand_err   = SW'(err_i);

endmodule

// File: rtl/can_bt_best.sv
module can_bt_best #(
  parameter int unsigned PW  = 7,
  parameter int unsigned T1W = 5,
  parameter int unsigned T2W = 4,
  parameter int unsigned SW  = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           eval_en,
  input  logic           cand_valid,
  input  logic [PW-1:0]  cand_presc,
  input  logic [T1W-1:0] cand_t1,
  input  logic [T2W-1:0] cand_t2,
  input  logic [SW-1:0]  cand_sp,
  input  logic [SW-1:0]  cand_err,
  output logic           cand_better,
  output logic           best_found,
  output logic [PW-1:0]  best_presc,
  output logic [T1W-1:0] best_t1,
  output logic [T2W-1:0] best_t2,
  output logic [SW-1:0]  best_sp
);

  logic [SW-1:0] best_err;

  // Strictly smaller error only: earlier candidates carry more quanta
  assign cand_better = eval_en && cand_valid && (!best_found || (cand_err < best_err));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_found <= 1'b0;
      best_presc <= '0;
      best_t1    <= '0;
      best_t2    <= '0;
      best_sp    <= '0;
      best_err   <= '0;
    end else if (clear) begin
      best_found <= 1'b0;
      best_presc <= '0;
      best_t1    <= '0;
      best_t2    <= '0;
      best_sp    <= '0;
      best_err   <= '0;
    end else if (cand_better) begin
      best_found <= 1'b1;
      best_presc <= cand_presc;
      best_t1    <= cand_t1;
      best_t2    <= cand_t2;
      best_sp    <= cand_sp;
      best_err   <= cand_err;
    end
  end

endmodule

// File: rtl/can_bt_solver.sv
module can_bt_solver
  import can_bt_pkg::*;
#(
  parameter int unsigned PRESC_MAX = 64,
  parameter int unsigned NQ_MIN    = 8,
  parameter int unsigned NQ_MAX    = 25,
  parameter int unsigned TSEG1_MAX = 16,
  parameter int unsigned TSEG2_MAX = 8,
  parameter int unsigned CW        = 9,
  parameter int unsigned RW        = 10,
  parameter int unsigned SW        = 10,
  localparam int unsigned PW  = $clog2(PRESC_MAX + 1),
  localparam int unsigned NQW = $clog2(NQ_MAX + 1),
  localparam int unsigned T1W = $clog2(TSEG1_MAX + 1),
  localparam int unsigned T2W = $clog2(TSEG2_MAX + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [CW-1:0]  clk_mhz,
  input  logic [RW-1:0]  rate_kbps,
  input  logic [SW-1:0]  sp_target_pm,
  output logic           busy,
  output logic           done,
  output logic           found,
  output logic [PW-1:0]  presc,
  output logic [T1W-1:0] tseg1,
  output logic [T2W-1:0] tseg2,
  output logic [SW-1:0]  sp_ach_pm,
  output logic [7:0]     btr_presc,
  output logic [7:0]     btr_seg
);

  // Named internal events
  logic           start_accept;
  logic           eval_en;
  logic           scan_last;
  logic           finish;
  logic           cand_valid;
  logic           cand_better;
  logic [PW-1:0]  scan_presc;
  logic [NQW-1:0] scan_nq;
  logic [T1W-1:0] cand_t1;
  logic [T2W-1:0] cand_t2;
  logic [SW-1:0]  cand_sp;
  logic [SW-1:0]  cand_err;
  logic           best_found;
  logic [PW-1:0]  best_presc;
  logic [T1W-1:0] best_t1;
  logic [T2W-1:0] best_t2;
  logic [SW-1:0]  best_sp;

  // Request captured at acceptance
  logic [CW-1:0] lat_clk;
  logic [RW-1:0] lat_rate;
  logic [SW-1:0] lat_sp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_clk  <= '0;
      lat_rate <= '0;
      lat_sp   <= '0;
    end else if (start_accept) begin
      lat_clk  <= clk_mhz;
      lat_rate <= rate_kbps;
      lat_sp   <= sp_target_pm;
    end
  end

  can_bt_scan #(
    .PRESC_MAX(PRESC_MAX),
    .NQ_MIN   (NQ_MIN),
    .NQ_MAX   (NQ_MAX)
  ) scan_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .start_accept(start_accept),
    .eval_en     (eval_en),
    .scan_last   (scan_last),
    .finish      (finish),
    .presc_q     (scan_presc),
    .nq_q        (scan_nq)
  );

  can_bt_eval #(
    .PW       (PW),
    .NQW      (NQW),
    .T1W      (T1W),
    .T2W      (T2W),
    .CW       (CW),
    .RW       (RW),
    .SW       (SW),
    .TSEG1_MAX(TSEG1_MAX),
    .TSEG2_MAX(TSEG2_MAX)
  ) eval_i (
    .presc     (scan_presc),
    .nq        (scan_nq),
    .clk_mhz   (lat_clk),
    .rate_kbps (lat_rate),
    .sp_target (lat_sp),
    .cand_valid(cand_valid),
    .cand_t1   (cand_t1),
    .cand_t2   (cand_t2),
    .cand_sp   (cand_sp),
    .cand_err  (cand_err)
  );

  can_bt_best #(
    .PW (PW),
    .T1W(T1W),
    .T2W(T2W),
    .SW (SW)
  ) best_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (start_accept),
    .eval_en    (eval_en),
    .cand_valid (cand_valid),
    .cand_presc (scan_presc),
    .cand_t1    (cand_t1),
    .cand_t2    (cand_t2),
    .cand_sp    (cand_sp),
    .cand_err   (cand_err),
    .cand_better(cand_better),
    .best_found (best_found),
    .best_presc (best_presc),
    .best_t1    (best_t1),
    .best_t2    (best_t2),
    .best_sp    (best_sp)
  );

  // Result registers, loaded once per search
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      found     <= 1'b0;
      presc     <= '0;
      tseg1     <= '0;
      tseg2     <= '0;
      sp_ach_pm <= '0;
    end else begin
      done <= finish;
      if (finish) begin
        found     <= best_found;
        presc     <= best_presc;
        tseg1     <= best_t1;
        tseg2     <= best_t2;
        sp_ach_pm <= best_sp;
      end
    end
  end

  // Two-byte register image; field positions fixed by the image layout
  logic [PW-1:0]  presc_m1;
  logic [T1W-1:0] t1_m1;
  logic [T2W-1:0] t2_m1;

  assign presc_m1  = presc - PW'(1);
  assign t1_m1     = tseg1 - T1W'(1);
  assign t2_m1     = tseg2 - T2W'(1);
  assign btr_presc = found ? 8'(presc_m1) : 8'h00;
  assign btr_seg   = found ? {1'b0, t2_m1[2:0], t1_m1[3:0]} : 8'h00;

endmodule

// File: rtl/can_bt_solver_chk.sv
module can_bt_solver_chk #(
  parameter int unsigned PRESC_MAX = 64,
  parameter int unsigned NQ_MIN    = 8,
  parameter int unsigned NQ_MAX    = 25,
  parameter int unsigned TSEG1_MAX = 16,
  parameter int unsigned TSEG2_MAX = 8,
  parameter int unsigned CW        = 9,
  parameter int unsigned RW        = 10,
  parameter int unsigned SW        = 10,
  localparam int unsigned PW  = $clog2(PRESC_MAX + 1),
  localparam int unsigned T1W = $clog2(TSEG1_MAX + 1),
  localparam int unsigned T2W = $clog2(TSEG2_MAX + 1),
  localparam int unsigned LAT = PRESC_MAX * (NQ_MAX - NQ_MIN + 1) + 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_accept,
  input logic           busy,
  input logic           done,
  input logic           found,
  input logic [PW-1:0]  presc,
  input logic [T1W-1:0] tseg1,
  input logic [T2W-1:0] tseg2,
  input logic [SW-1:0]  sp_ach_pm,
  input logic [7:0]     btr_presc,
  input logic [7:0]     btr_seg,
  input logic [CW-1:0]  lat_clk,
  input logic [RW-1:0]  lat_rate
);

  logic run_q;
  int   cnt_q;
  int   nq_w;

  assign nq_w = 1 + int'(tseg1) + int'(tseg2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= 0;
    end else if (start_accept) begin
      run_q <= 1'b1;
      cnt_q <= 0;
    end else if (done) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q + 1;
    end
  end

  assert_exact_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found) |-> (int'(presc) * nq_w * int'(lat_rate) == int'(lat_clk) * 1000));

  assert_seg_limits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found) |-> (presc >= PW'(1) && int'(presc) <= PRESC_MAX &&
                         tseg1 >= T1W'(1) && int'(tseg1) <= TSEG1_MAX &&
                         tseg2 >= T2W'(1) && int'(tseg2) <= TSEG2_MAX &&
                         nq_w >= NQ_MIN && nq_w <= NQ_MAX));

  assert_sp_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found) |-> (int'(sp_ach_pm) * nq_w <= (1 + int'(tseg1)) * 1000 &&
                         (int'(sp_ach_pm) + 1) * nq_w > (1 + int'(tseg1)) * 1000));

  assert_image_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found) |-> (int'(btr_presc) + 1 == int'(presc) && !btr_seg[7] &&
                         int'(btr_seg[6:4]) + 1 == int'(tseg2) &&
                         int'(btr_seg[3:0]) + 1 == int'(tseg1)));

  assert_empty_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !found) |-> (presc == '0 && tseg1 == '0 && tseg2 == '0 &&
                          sp_ach_pm == '0 && btr_presc == 8'h00 && btr_seg == 8'h00));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_due_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_q && cnt_q == LAT));

  assert_done_on_time_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q == LAT) |-> done);

  assert_busy_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_hold_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (done || ($stable(btr_presc) && $stable(btr_seg) && $stable(found))));

endmodule

bind can_bt_solver can_bt_solver_chk #(
  .PRESC_MAX(PRESC_MAX),
  .NQ_MIN   (NQ_MIN),
  .NQ_MAX   (NQ_MAX),
  .TSEG1_MAX(TSEG1_MAX),
  .TSEG2_MAX(TSEG2_MAX),
  .CW       (CW),
  .RW       (RW),
  .SW       (SW)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_accept(start_accept),
  .busy        (busy),
  .done        (done),
  .found       (found),
  .presc       (presc),
  .tseg1       (tseg1),
  .tseg2       (tseg2),
  .sp_ach_pm   (sp_ach_pm),
  .btr_presc   (btr_presc),
  .btr_seg     (btr_seg),
  .lat_clk     (lat_clk),
  .lat_rate    (lat_rate)
);

// File: tb/can_bt_solver_tb_top.sv
module can_bt_solver_tb_top;

  localparam int SCAN_CYCLES = 64 * 18 + 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [8:0] clk_mhz = '0;
  logic [9:0] rate_kbps = '0;
  logic [9:0] sp_target_pm = '0;
  logic       busy, done, found;
  logic [6:0] presc;
  logic [4:0] tseg1;
  logic [3:0] tseg2;
  logic [9:0] sp_ach_pm;
  logic [7:0] btr_presc, btr_seg;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  can_bt_solver dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .clk_mhz(clk_mhz),
    .rate_kbps(rate_kbps), .sp_target_pm(sp_target_pm), .busy(busy),
    .done(done), .found(found), .presc(presc), .tseg1(tseg1),
    .tseg2(tseg2), .sp_ach_pm(sp_ach_pm), .btr_presc(btr_presc),
    .btr_seg(btr_seg)
  );

  task automatic check(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Independent restatement: walk quanta counts downward, derive prescaler by division
  task automatic ref_solve(int c, int r, int sp, output int f, output int p,
                           output int t1, output int t2, output int sa);
    int best_err;
    f = 0; p = 0; t1 = 0; t2 = 0; sa = 0; best_err = 0;
    if (r == 0) return;
    if ((c * 1000) % r != 0) return;
    for (int nq = 25; nq >= 8; nq--) begin
      int bits_q, pp, x2, x1, s, e, lo, hi;
      bits_q = (c * 1000) / r;
      if (bits_q % nq != 0) continue;
      pp = bits_q / nq;
      if (pp < 1 || pp > 64) continue;
      x2 = (2 * (1000 - sp) * nq + 1000) / 2000;
      lo = (nq - 17 > 1) ? nq - 17 : 1;
      hi = (nq - 2 < 8) ? nq - 2 : 8;
      if (x2 < lo) x2 = lo;
      if (x2 > hi) x2 = hi;
      x1 = nq - 1 - x2;
      s = ((x1 + 1) * 1000) / nq;
      e = (s > sp) ? s - sp : sp - s;
      if (f == 0 || e < best_err) begin
        f = 1; p = pp; t1 = x1; t2 = x2; sa = s; best_err = e;
      end
    end
  endtask

  // Cycle model
  int m_cnt = 0;
  bit m_busy = 0, m_done = 0;
  int m_f = 0, m_p = 0, m_t1 = 0, m_t2 = 0, m_sa = 0;
  int p_f, p_p, p_t1, p_t2, p_sa;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_cnt = 0;
      m_f = 0; m_p = 0; m_t1 = 0; m_t2 = 0; m_sa = 0;
    end else if (m_busy) begin
      m_cnt++;
      m_done = 0;
      if (m_cnt == SCAN_CYCLES) begin
        m_busy = 0; m_done = 1;
        m_f = p_f; m_p = p_p; m_t1 = p_t1; m_t2 = p_t2; m_sa = p_sa;
      end
    end else begin
      m_done = 0;
      if (start) begin
        m_busy = 1; m_cnt = 0;
        ref_solve(int'(clk_mhz), int'(rate_kbps), int'(sp_target_pm), p_f, p_p, p_t1, p_t2, p_sa);
      end
    end
  end

  always @(negedge clk) begin
    int eb0, eb1;
    eb0 = m_f ? (m_p - 1) : 0;
    eb1 = m_f ? (((m_t2 - 1) << 4) | (m_t1 - 1)) : 0;
    check("R9", "busy", int'(busy), int'(m_busy));
    check("R9", "done", int'(done), int'(m_done));
    check("R8", "found", int'(found), m_f);
    check("R5", "presc", int'(presc), m_p);
    check("R4", "tseg1", int'(tseg1), m_t1);
    check("R4", "tseg2", int'(tseg2), m_t2);
    check("R6", "sp_ach_pm", int'(sp_ach_pm), m_sa);
    check("R7", "btr_presc", int'(btr_presc), eb0);
    check("R7", "btr_seg", int'(btr_seg), eb1);
  end

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  // Exact bit time and segment ranges of the held result
  task automatic check_legal(int c, int r);
    int nq;
    nq = 1 + int'(tseg1) + int'(tseg2);
    check("R2", "exact bit time", int'(presc) * nq * r, c * 1000);
    check("R3", "segment ranges",
          int'(presc >= 1 && presc <= 64 && tseg1 >= 1 && tseg1 <= 16 &&
               tseg2 >= 1 && tseg2 <= 8 && nq >= 8 && nq <= 25), 1);
  endtask

  task automatic run(int c, int r, int sp, bit disturb);
    @(posedge clk); #1;
    clk_mhz = 9'(c); rate_kbps = 10'(r); sp_target_pm = 10'(sp); start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    // R10: scramble inputs during the search
    clk_mhz = 9'd7; rate_kbps = 10'd3; sp_target_pm = 10'd500;
    if (disturb) begin
      repeat (100) @(posedge clk);
      #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
    end
    wait_done();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "busy in reset", int'(busy), 0);
    check("R1", "done in reset", int'(done), 0);
    check("R1", "image in reset", int'({btr_presc, btr_seg}), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1", "found after reset", int'(found), 0);
    check("R1", "presc after reset", int'(presc), 0);

    // R11: worked example
    run(8, 125, 875, 1'b0);
    check("R11", "byte0", int'(btr_presc), 8'h03);
    check("R11", "byte1", int'(btr_seg), 8'h1C);
    check_legal(8, 125);

    // R5: tie between 16 and 8 quanta, both error 0 -> 16 quanta, prescaler 2
    run(16, 500, 500, 1'b0);
    check("R5", "tie presc", int'(presc), 2);
    check("R5", "tie quanta", 1 + int'(tseg1) + int'(tseg2), 16);
    check_legal(16, 500);

    // R4: clamp, 25 quanta at target 100
    run(25, 1000, 100, 1'b0);
    check("R4", "clamped tseg2", int'(tseg2), 8);
    check("R4", "clamped tseg1", int'(tseg1), 16);
    check("R6", "clamped sp", int'(sp_ach_pm), 680);

    // R8: no exact division
    run(7, 1000, 875, 1'b0);
    check("R8", "found", int'(found), 0);
    check("R8", "image", int'({btr_presc, btr_seg}), 0);

    // R8: prescaler range exceeded
    run(300, 10, 875, 1'b0);
    check("R8", "found large ratio", int'(found), 0);

    // R10: start while busy ignored, inputs captured at acceptance
    run(100, 125, 750, 1'b1);
    check("R10", "found", int'(found), 1);
    check_legal(100, 125);
    @(negedge clk);
    check("R9", "done one cycle", int'(done), 0);

    run(16, 500, 875, 1'b0);
    check("R5", "presc 16MHz", int'(presc), 2);
    check("R7", "byte1 16MHz", int'(btr_seg), 8'h1C);
    check_legal(16, 500);

    repeat (5) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule